// File: doc/BRIEF.md
# Word-Parallel Integer Clock Divider

This block produces a divided clock as a stream of parallel bit-words rather than as a toggling signal. It is clocked by a slow word clock. On every word-clock cycle it emits one word of `SYM_W` output-clock samples. An external serializer then shifts the word out at the fast bit rate, so each bit of the word lasts one fast-clock period. Because the whole waveform is built a word at a time in the slow domain, no counting or comparing logic has to run at the fast rate.

The divide factor is `S = S_MIN + div_cfg_i`. With the default 20-bit configuration, S covers every integer from 8 to 1048583. The block tracks the bit position within the current output period in a phase accumulator. It marks each bit high while that position lies in the first half of the period. For even S the two halves are equal. For odd S the high half is longer by one bit.

Each word also carries a flag and a bit index showing where a new output period begins. A new configuration is taken only at such a period start, so a running period keeps its length. A synchronous reset returns the generator to the first bit of a period, with the output high.

Top module: `sym_clkdiv`

## Requirements
- R1: Each full output period lasts exactly S = 8 + `div_cfg_i` serialized bits, for any configuration value from 0 to 2^20-1.
- R2: For even S, each period holds S/2 consecutive high bits followed by S/2 consecutive low bits.
- R3: For odd S, each period holds (S+1)/2 consecutive high bits followed by (S-1)/2 consecutive low bits.
- R4: While `srst_i` is high at a clock edge, that edge loads an all-zero `sym_o` and a low `period_start_o`. The first word after release begins a new period at bit 0, which is high.
- R5: One word is produced per clock with no gaps. Bit i of `sym_o` (bit 0 first) is serialized bit 8*n+i of the stream, where n counts words since reset.
- R6: `period_start_o` is high exactly in those words where some bit is position 0 of a period, and `start_pos_o` gives that bit's index (0 to 7).
- R7: `div_cfg_i` is sampled only at the bit where a period begins. A change made at any other time leaves the length of the running period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock (one edge per output word) |
| srst_i | input | 1 | Synchronous reset, active high |
| div_cfg_i | input | 20 | Divide configuration; S = 8 + value |
| sym_o | output | 8 | Output-clock samples, bit 0 serialized first |
| period_start_o | output | 1 | Word contains the first bit of a period |
| start_pos_o | output | 3 | Bit index of that first bit within the word |

## Verification
The corner cases are the smallest factors 8, 9 and 10, where a period is barely one word long and a boundary falls at every bit index in turn. At these factors a design that mishandles the in-word wrap either drops a bit or doubles one, and the run lengths come out one too long or too short. The largest factor, 1048583, with a large odd factor beside it, exposes accumulator truncation and off-by-one errors in the rounding of the high half. A configuration change made mid-period would, if taken immediately, cut short or stretch the running period. A reset issued mid-period that fails to return the phase to zero would make the next period start at a nonzero bit index or in the low phase.

// File: rtl/sym_clkdiv_pkg.sv
package sym_clkdiv_pkg;
   typedef enum logic {
      ORDER_MSB_FIRST = 1'b0,
      ORDER_LSB_FIRST = 1'b1
   } ser_order_e;

   function automatic int unsigned phase_bits(input int unsigned s_min, input int unsigned cfg_w);
      return $clog2(s_min + (32'd1 << cfg_w));
   endfunction
endpackage

// File: rtl/sym_clkdiv_cfg.sv
module sym_clkdiv_cfg #(
   parameter int CFG_W = 20,
   parameter int S_MIN = 8,
   parameter int PH_W  = 21
) (
   input  logic [CFG_W-1:0] cfg_i,
   output logic [PH_W-1:0]  s_o,
   output logic [PH_W-1:0]  h_o
);
   logic [PH_W:0] s_plus1;

   always_comb begin
      s_o     = PH_W'(S_MIN) + PH_W'(cfg_i);
      s_plus1 = {1'b0, s_o} + (PH_W+1)'(1);
      h_o     = s_plus1[PH_W:1];
   end
endmodule

// File: rtl/sym_clkdiv_phase.sv
module sym_clkdiv_phase #(
   parameter int SYM_W = 8,
   parameter int S_MIN = 8,
   parameter int PH_W  = 21,
   parameter int IDX_W = 3
) (
   input  logic             clk_i,
   input  logic             srst_i,
   input  logic [PH_W-1:0]  s_new_i,
   input  logic [PH_W-1:0]  h_new_i,
   output logic [PH_W-1:0]  ph_o,
   output logic [PH_W-1:0]  h_act_o,
   output logic             start_here_o,
   output logic [IDX_W-1:0] start_idx_o
);
   logic [PH_W-1:0] ph_q, s_act_q, h_act_q, ph_nxt, diff;
   logic [PH_W:0]   sum, tail;
   logic            mid_wrap, at_zero;

   always_comb begin
      at_zero      = (ph_q == '0);
      sum          = {1'b0, ph_q} + (PH_W+1)'(SYM_W);
      mid_wrap     = sum > {1'b0, s_act_q};
      start_here_o = at_zero || mid_wrap;
      diff         = s_act_q - ph_q;
      start_idx_o  = at_zero ? '0 : diff[IDX_W-1:0];
      tail         = (PH_W+1)'(SYM_W) - (PH_W+1)'(start_idx_o);
      if (start_here_o)
         ph_nxt = (tail == {1'b0, s_new_i}) ? '0 : tail[PH_W-1:0];
      else
         ph_nxt = (sum == {1'b0, s_act_q}) ? '0 : sum[PH_W-1:0];
   end

   always_ff @(posedge clk_i) begin
      if (srst_i) begin
         ph_q    <= '0;
         s_act_q <= PH_W'(S_MIN);
         h_act_q <= PH_W'((S_MIN + 1) / 2);
      end else begin
         ph_q <= ph_nxt;
         if (start_here_o) begin
            s_act_q <= s_new_i;
            h_act_q <= h_new_i;
         end
      end
   end

   assign ph_o    = ph_q;
   assign h_act_o = h_act_q;

   AST_PH_RANGE: assert property (@(posedge clk_i) disable iff (srst_i)
      ph_q < s_act_q); // R1

   AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (srst_i)
      (!start_here_o && !$past(srst_i)) |=> $stable(s_act_q)); // R7
endmodule

// File: rtl/sym_clkdiv_bits.sv
module sym_clkdiv_bits #(
   parameter int SYM_W = 8,
   parameter int PH_W  = 21,
   parameter int IDX_W = 3
) (
   input  logic [PH_W-1:0]  ph_i,
   input  logic [PH_W-1:0]  h_act_i,
   input  logic [PH_W-1:0]  h_new_i,
   input  logic             start_here_i,
   input  logic [IDX_W-1:0] start_idx_i,
   output logic [SYM_W-1:0] word_o
);
   for (genvar i = 0; i < SYM_W; i++) begin : g_bit
      logic          in_new;
      logic [PH_W:0] pos_old;
      logic [PH_W-1:0] pos_new;
      always_comb begin
         in_new  = start_here_i && (IDX_W'(i) >= start_idx_i);
         pos_old = {1'b0, ph_i} + (PH_W+1)'(i);
         pos_new = PH_W'(i) - PH_W'(start_idx_i);
         word_o[i] = in_new ? (pos_new < h_new_i) : (pos_old < {1'b0, h_act_i});
      end
   end
endmodule

// File: rtl/sym_clkdiv.sv
module sym_clkdiv
   import sym_clkdiv_pkg::*;
#(
   parameter int         CFG_W = 20,
   parameter int         SYM_W = 8,
   parameter int         S_MIN = 8,
   parameter ser_order_e ORDER = ORDER_LSB_FIRST
) (
   input  logic                       clk_i,
   input  logic                       srst_i,
   input  logic [CFG_W-1:0]           div_cfg_i,
   output logic [SYM_W-1:0]           sym_o,
   output logic                       period_start_o,
   output logic [$clog2(SYM_W)-1:0]   start_pos_o
);
   localparam int PH_W  = phase_bits(S_MIN, CFG_W);
   localparam int IDX_W = $clog2(SYM_W);

   if (SYM_W < 2)       begin : g_chk_w   $error("SYM_W must be at least 2");          end
   if (SYM_W > S_MIN)   begin : g_chk_s   $error("S_MIN must not be below SYM_W");     end
   if (CFG_W > 24)      begin : g_chk_c   $error("CFG_W limited to 24 bits");          end

   logic [PH_W-1:0]  s_new, h_new, ph, h_act;
   logic             start_here;
   logic [IDX_W-1:0] start_idx;
   logic [SYM_W-1:0] word_d, word_q;
   logic             start_q;
   logic [IDX_W-1:0] idx_q;

   sym_clkdiv_cfg #(.CFG_W(CFG_W), .S_MIN(S_MIN), .PH_W(PH_W)) u_cfg (
      .cfg_i (div_cfg_i),
      .s_o   (s_new),
      .h_o   (h_new)
   );

   sym_clkdiv_phase #(.SYM_W(SYM_W), .S_MIN(S_MIN), .PH_W(PH_W), .IDX_W(IDX_W)) u_phase (
      .clk_i        (clk_i),
      .srst_i       (srst_i),
      .s_new_i      (s_new),
      .h_new_i      (h_new),
      .ph_o         (ph),
      .h_act_o      (h_act),
      .start_here_o (start_here),
      .start_idx_o  (start_idx)
   );

   sym_clkdiv_bits #(.SYM_W(SYM_W), .PH_W(PH_W), .IDX_W(IDX_W)) u_bits (
      .ph_i         (ph),
      .h_act_i      (h_act),
      .h_new_i      (h_new),
      .start_here_i (start_here),
      .start_idx_i  (start_idx),
      .word_o       (word_d)
   );

   always_ff @(posedge clk_i) begin
      if (srst_i) begin
         word_q  <= '0;
         start_q <= 1'b0;
         idx_q   <= '0;
      end else begin
         word_q  <= word_d;
         start_q <= start_here;
         idx_q   <= start_idx;
      end
   end

   if (ORDER == ORDER_LSB_FIRST) begin : g_lsb
      assign sym_o = word_q;
   end else begin : g_msb
      for (genvar j = 0; j < SYM_W; j++) begin : g_rev
         assign sym_o[j] = word_q[SYM_W-1-j];
      end
   end

   assign period_start_o = start_q;
   assign start_pos_o    = idx_q;

   AST_RST_START: assert property (@(posedge clk_i) disable iff (srst_i)
      $fell(srst_i) |=> (period_start_o && start_pos_o == '0 && word_q[0])); // R4

   AST_FIRST_HIGH: assert property (@(posedge clk_i) disable iff (srst_i)
      period_start_o |-> word_q[start_pos_o]); // R6

   AST_TAIL_LOW: assert property (@(posedge clk_i) disable iff (srst_i)
      (period_start_o && start_pos_o != '0) |-> !word_q[start_pos_o - 1'b1]); // R3
endmodule

// File: tb/sym_clkdiv_bench.sv
module sym_clkdiv_bench;
   logic        clk = 1'b0;
   logic        srst;
   logic [19:0] cfg;
   logic [7:0]  sym;
   logic        pstart;
   logic [2:0]  ppos;

   int n_vec = 0, n_bad = 0;
   int mp, m_s;
   bit prev_rst;
   bit meas_on;
   int lvl, run, hi_len;
   bit hi_valid;
   string ctx;

   always #2 clk = ~clk;

   sym_clkdiv u_sym_clkdiv (
      .clk_i(clk), .srst_i(srst), .div_cfg_i(cfg),
      .sym_o(sym), .period_start_o(pstart), .start_pos_o(ppos)
   );

   task automatic fail_line(input string req, input string what, input longint act, input longint exp);
      n_bad++;
      $display("FAIL %s (%s) %s: actual %0d expected %0d", req, ctx, what, act, exp);
   endtask

   task automatic meas_reset();
      lvl = 1; run = 0; hi_valid = 0;
   endtask

   task automatic feed_bit(input int b);
      if (!meas_on) return;
      if (b == lvl) run++;
      else begin
         if (lvl == 1) begin
            hi_len = run; hi_valid = 1;
         end else if (hi_valid) begin
            n_vec++;
            if ((m_s % 2) == 0) begin
               if (hi_len != m_s/2 || run != m_s/2) fail_line("R2", "high/low run", hi_len*10000000 + run, (m_s/2)*10000000 + m_s/2);
            end else begin
               if (hi_len != (m_s+1)/2 || run != (m_s-1)/2) fail_line("R3", "high/low run", hi_len*10000000 + run, ((m_s+1)/2)*10000000 + (m_s-1)/2);
            end
            n_vec++;
            if (hi_len + run != m_s) fail_line("R1", "period length", hi_len + run, m_s);
            hi_valid = 0;
         end
         lvl = b; run = 1;
      end
   endtask

   task automatic check_word();
      logic [7:0] e;
      bit es;
      int ei;
      if (srst) begin
         n_vec++;
         if (sym !== 8'h00 || pstart !== 1'b0) fail_line("R4", "word during reset", {pstart, sym}, 0);
         mp = 0; meas_reset(); prev_rst = 1;
         return;
      end
      es = 0; ei = 0;
      for (int i = 0; i < 8; i++) begin
         if (mp == 0) begin
            m_s = 8 + int'(cfg);
            es = 1; ei = i;
         end
         e[i] = (mp < (m_s + 1) / 2);
         feed_bit(int'(e[i]));
         mp++;
         if (mp == m_s) mp = 0;
      end
      if (prev_rst) begin
         n_vec++;
         if (pstart !== 1'b1 || ppos !== 3'd0 || sym[0] !== 1'b1)
            fail_line("R4", "first word after release", {pstart, ppos, sym[0]}, {1'b1, 3'd0, 1'b1});
      end
      prev_rst = 0;
      n_vec++;
      if (sym !== e) fail_line(ctx == "cfg-change" ? "R7" : "R5", "word bits", sym, e);
      n_vec++;
      if (pstart !== es || (es && ppos !== 3'(ei)))
         fail_line("R6", "start flag/index", {pstart, ppos}, {es, 3'(ei)});
   endtask

   task automatic run_words(input int n);
      for (int w = 0; w < n; w++) begin
         @(posedge clk);
         @(negedge clk);
         check_word();
      end
   endtask

   task automatic restart(input logic [19:0] c, input bit m);
      cfg = c; srst = 1'b1; meas_on = m;
      run_words(1);
      srst = 1'b0;
   endtask

   initial begin
      srst = 1'b1; cfg = '0; meas_on = 0; prev_rst = 0; mp = 0; m_s = 8;
      meas_reset();
      ctx = "reset";
      @(negedge clk);
      run_words(3);
      for (int c = 0; c < 3; c++) begin
         ctx = $sformatf("S=%0d", 8 + c);
         restart(20'(c), 1);
         run_words(40);
      end
      ctx = "cfg-change";          // R7: change applied only at next boundary
      restart(20'd1, 0);
      run_words(5);
      cfg = 20'd2;
      run_words(30);
      ctx = "S=100001";
      restart(20'd99993, 1);
      run_words(6000);
      ctx = "mid-reset";           // R4: reset in the middle of a period
      srst = 1'b1;
      run_words(1);
      srst = 1'b0;
      run_words(12510);
      ctx = "S=1048583";           // R1: top of range
      restart(20'hFFFFF, 1);
      run_words(131075);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog (%s): actual %0d expected %0d", ctx, 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule